// File: doc/BRIEF.md
# Soft Power-On Sequencer

This block drives the gate of a switch that feeds a target board's supply. A target that draws a large current the moment it is powered can pull the host's own rails outside their safe range. To avoid that, the block raises the supply in steps. When the power-enable request goes from low to high, it runs a fixed number of switching periods. Each period starts with an off stretch and ends with an on stretch. When the last period ends, the switch stays on for as long as the request stays high.

A host programs three values: the number of periods, the period length in clocks and the off time inside each period. The block captures them when a sequence starts, so the host may rewrite them at any time. A bypass input skips the soft start, and the switch then follows the request directly. Dropping the request cuts the power at once and abandons any sequence that is running.

Top module: `softstart_seq`

## Requirements
- R1: After reset, and while `pwr_en` is low, `sw_on` and `busy` are both low.
- R2: With `bypass` low, a low-to-high change of `pwr_en` starts a sequence. From the first clock edge that samples `pwr_en` high (with the previous sample low), `busy` is high. Before that edge, `sw_on` stays low.
- R3: Count the clocks of a period from 0, starting at the edge that starts the period. `sw_on` is low during clocks 0 to `cfg_off`−1 and high during the remaining clocks of the period.
- R4: The sequence is exactly `cfg_bursts` periods long, so `busy` is high for `cfg_bursts` × period clocks. After that, `busy` is low and `sw_on` stays high until `pwr_en` falls.
- R5: If `cfg_bursts` is 0 when the sequence starts, `sw_on` goes high at the start edge and `busy` never rises.
- R6: An off time equal to or larger than the period keeps the whole period off. An off time of 0 keeps the whole period on.
- R7: A period length of 0 is treated as a period of one clock.
- R8: When `pwr_en` goes low, `sw_on` falls in the same cycle without waiting for a clock edge. The sequence is abandoned, and `busy` is low after the next edge. The next rise of `pwr_en` starts again from the first period.
- R9: The three parameters are captured at the start edge. Changing them while a sequence runs has no effect on that sequence.
- R10: While `bypass` is high, `sw_on` equals `pwr_en` without waiting for a clock edge, and `busy` is low after the next edge. If `bypass` is raised during a sequence, the sequence ends with power held on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_en | input | 1 | Power request |
| bypass | input | 1 | Skip the soft start; the switch follows `pwr_en` |
| cfg_bursts | input | 8 | Number of switching periods |
| cfg_period | input | 16 | Period length in clocks |
| cfg_off | input | 16 | Off clocks at the start of each period |
| sw_on | output | 1 | Gate control of the supply switch |
| busy | output | 1 | A soft-start sequence is running |

## Verification
The bench goes after the boundaries of the count:
- An off-by-one in the period or burst counter would show as a sequence that is one clock or one period too long or too short, which is seen as a misplaced fall of `busy`.
- Zero bursts, a zero period, a zero off time and an off time at or past the period are each run directly. A design that got one of these wrong would hang in the sequence or never turn on.
- Parameters are rewritten while a sequence runs. A design that does not capture them at the start would change its waveform partway through.
- A sequence is abandoned and then restarted, and bypass is raised in the middle of a sequence. Done wrong, these leave the switch on after the request drops, or resume a stale sequence.

// File: rtl/ssq_pkg.sv
// Shared types and reset constants for the soft power-on sequencer.
package ssq_pkg;
    // Sequencer state: no power, switching periods, steady on
    typedef enum logic [1:0] {
        SSQ_IDLE = 2'd0,
        SSQ_RUN  = 2'd1,
        SSQ_HOLD = 2'd2
    } ssq_state_e;

    // Values the captured parameters take after reset
    localparam int unsigned SSQ_DEF_BURSTS = 35;
    localparam int unsigned SSQ_DEF_PERIOD = 2000;
    localparam int unsigned SSQ_DEF_OFF    = 1995;
endpackage

// File: rtl/ssq_cfg_latch.sv
// Holds the parameters that are in force for the running sequence.
// Assumes: load pulses for one cycle at the start edge. A period of zero
// is stored as one so that the counters downstream always see a period of
// at least one clock.
module ssq_cfg_latch #(
    parameter int unsigned CW     = 8,
    parameter int unsigned TW     = 16,
    parameter int unsigned DEF_B  = 35,
    parameter int unsigned DEF_P  = 2000,
    parameter int unsigned DEF_O  = 1995
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] in_bursts,
    input  logic [TW-1:0] in_period,
    input  logic [TW-1:0] in_off,
    output logic [CW-1:0] out_bursts,
    output logic [TW-1:0] out_period,
    output logic [TW-1:0] out_off
);
    localparam logic [TW-1:0] ONE_T = TW'(1);

    // Capture the host values at the start edge, clamping a zero period to one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_bursts <= CW'(DEF_B);
            out_period <= TW'(DEF_P);
            out_off    <= TW'(DEF_O);
        end else if (load) begin
            out_bursts <= in_bursts;
            out_period <= (in_period == '0) ? ONE_T : in_period;
            out_off    <= in_off;
        end
    end
endmodule

// File: rtl/ssq_phase_timer.sv
// Counts the clocks inside one switching period and reports which part of
// the period is current.
// Assumes: period >= 1, and period and off_len hold still while advance is high.
module ssq_phase_timer #(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    input  logic [TW-1:0] period,
    input  logic [TW-1:0] off_len,
    output logic          on_phase,
    output logic          wrap
);
    logic [TW-1:0] cnt;

    // Position inside the period; returns to zero on the last clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (advance) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

    // High on the last clock of the period
    always_comb wrap = (cnt == period - 1'b1);

    // The on part of the period begins once the off clocks have passed
    always_comb on_phase = (cnt >= off_len);
endmodule

// File: rtl/ssq_burst_count.sv
// Counts the switching periods that have finished and flags the last one.
// Assumes: total >= 1 whenever step can be high.
module ssq_burst_count #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [CW-1:0] total,
    output logic          last
);
    logic [CW-1:0] cnt;

    // Index of the period now running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (step && !last) begin
            cnt <= cnt + 1'b1;
        end
    end

    // High while the final period runs
    always_comb last = (cnt == total - 1'b1);
endmodule

// File: rtl/softstart_seq.sv
// Soft power-on sequencer: on a rising power request it runs a programmed
// burst of off-then-on periods, then holds the supply switch on.
// Assumes: one clock domain, and inputs that are already synchronous.
// sw_on is gated by pwr_en without a register in between, so the switch
// opens within the same cycle as the request drops.
module softstart_seq
    import ssq_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned TIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_en,
    input  logic             bypass,
    input  logic [CNT_W-1:0] cfg_bursts,
    input  logic [TIM_W-1:0] cfg_period,
    input  logic [TIM_W-1:0] cfg_off,
    output logic             sw_on,
    output logic             busy
);
    ssq_state_e       state, state_nxt;
    logic             en_q;
    logic             start;
    logic             in_run;
    logic             on_phase;
    logic             wrap;
    logic             last;
    logic [CNT_W-1:0] lat_bursts;
    logic [TIM_W-1:0] lat_period;
    logic [TIM_W-1:0] lat_off;

    // Previous sample of the request, used to find its rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= pwr_en;
    end

    // Rising edge of the request
    always_comb start = pwr_en && !en_q;

    // True while the switching periods run
    always_comb in_run = (state == SSQ_RUN);

    ssq_cfg_latch #(
        .CW    (CNT_W),
        .TW    (TIM_W),
        .DEF_B (SSQ_DEF_BURSTS),
        .DEF_P (SSQ_DEF_PERIOD),
        .DEF_O (SSQ_DEF_OFF)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start),
        .in_bursts  (cfg_bursts),
        .in_period  (cfg_period),
        .in_off     (cfg_off),
        .out_bursts (lat_bursts),
        .out_period (lat_period),
        .out_off    (lat_off)
    );

    ssq_phase_timer #(
        .TW (TIM_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .advance  (in_run),
        .period   (lat_period),
        .off_len  (lat_off),
        .on_phase (on_phase),
        .wrap     (wrap)
    );

    ssq_burst_count #(
        .CW (CNT_W)
    ) u_bursts (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .step  (in_run && wrap),
        .total (lat_bursts),
        .last  (last)
    );

    // Next state: a dropped request wins, then bypass, then the sequence itself
    always_comb begin
        state_nxt = state;
        if (!pwr_en) begin
            state_nxt = SSQ_IDLE;
        end else if (bypass) begin
            state_nxt = SSQ_HOLD;
        end else begin
            unique case (state)
                SSQ_IDLE: if (start) state_nxt = (cfg_bursts == '0) ? SSQ_HOLD : SSQ_RUN;
                SSQ_RUN:  if (wrap && last) state_nxt = SSQ_HOLD;
                SSQ_HOLD: state_nxt = SSQ_HOLD;
                default:  state_nxt = SSQ_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SSQ_IDLE;
        else        state <= state_nxt;
    end

    // Switch gate: always masked by the request so that power drops at once
    always_comb sw_on = pwr_en && (bypass || state == SSQ_HOLD || (in_run && on_phase));

    // Busy covers the switching periods only
    always_comb busy = in_run;
endmodule

// File: rtl/ssq_checker.sv
// Checker for the soft power-on sequencer. It watches only the ports and
// is attached to every instance of the top module with the bind below.
module ssq_checker (
    input logic clk,
    input logic rst_n,
    input logic pwr_en,
    input logic bypass,
    input logic sw_on,
    input logic busy
);
    // R8: a dropped request ends any sequence by the next edge
    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> !busy)
        else $error("p_abort_r8");

    // R10: bypass ends or prevents a sequence
    p_bypass_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> !busy)
        else $error("p_bypass_idle_r10");

    // R2: a sequence only begins from a request that was high with bypass low
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(pwr_en) && !$past(bypass)))
        else $error("p_start_r2");

    // R2: no power on the cycle that carries the request's rising edge
    p_dark_before_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pwr_en) && !bypass) |-> !sw_on)
        else $error("p_dark_before_r2");

    // R4: a sequence that ends under a held request leaves power on
    p_hold_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && pwr_en && $past(pwr_en)) |-> sw_on)
        else $error("p_hold_after_r4");

    // R4: steady-on power stays on while the request holds
    p_hold_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sw_on && pwr_en && !bypass) |=> (sw_on || !pwr_en))
        else $error("p_hold_stays_r4");
endmodule

bind softstart_seq ssq_checker u_ssq_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_en (pwr_en),
    .bypass (bypass),
    .sw_on  (sw_on),
    .busy   (busy)
);

// File: tb/softstart_seq_test.sv
module softstart_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_en = 1'b0;
    logic        bypass = 1'b0;
    logic [7:0]  cfg_bursts = '0;
    logic [15:0] cfg_period = '0;
    logic [15:0] cfg_off = '0;
    logic        sw_on;
    logic        busy;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    softstart_seq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_en     (pwr_en),
        .bypass     (bypass),
        .cfg_bursts (cfg_bursts),
        .cfg_period (cfg_period),
        .cfg_off    (cfg_off),
        .sw_on      (sw_on),
        .busy       (busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected switch state i clocks after the start edge
    function automatic int exp_on(int i, int b, int p, int o);
        int pe = (p == 0) ? 1 : p;
        if (i >= b * pe) return 1;
        return ((i % pe) >= o) ? 1 : 0;
    endfunction

    // Run a sequence and check every cycle; optionally rewrite the config mid-run
    task automatic run_check(input int b, input int p, input int o,
                             input int extra, input bit scramble);
        int pe = (p == 0) ? 1 : p;
        int total = b * pe;
        @(negedge clk);
        cfg_bursts = 8'(b); cfg_period = 16'(p); cfg_off = 16'(o);
        pwr_en = 1'b1;
        #1 chk("R2 dark before edge", int'(sw_on), 0);
        for (int i = 0; i < total + extra; i++) begin
            @(negedge clk);
            chk("R3 phase", int'(sw_on), exp_on(i, b, p, o));
            chk("R4 busy window", int'(busy), (i < total) ? 1 : 0);
            if (scramble && i == 1) begin
                cfg_bursts = 8'(b + 3);
                cfg_period = 16'(p + 7);
                cfg_off    = 16'($urandom_range(0, 20));
            end
        end
        pwr_en = 1'b0;
        #1 chk("R8 off at once", int'(sw_on), 0);
        @(negedge clk);
        chk("R1 idle busy", int'(busy), 0);
        chk("R1 idle sw", int'(sw_on), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset sw", int'(sw_on), 0);
        chk("R1 reset busy", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset sw", int'(sw_on), 0);
        chk("R1 after reset busy", int'(busy), 0);

        // R3 R4 plain pattern
        run_check(3, 10, 6, 5, 1'b0);
        // R5 zero bursts
        run_check(0, 10, 6, 4, 1'b0);
        // R6 off at and past the period; off zero
        run_check(2, 8, 8, 3, 1'b0);
        run_check(2, 8, 50, 3, 1'b0);
        run_check(3, 5, 0, 3, 1'b0);
        // R7 zero period
        run_check(4, 0, 0, 3, 1'b0);
        run_check(4, 0, 1, 3, 1'b0);
        // R9 config rewritten during the run
        run_check(3, 12, 4, 4, 1'b1);
        // long period near the reset values
        run_check(2, 2000, 1995, 4, 1'b0);

        // R8 abandon mid-run then restart from scratch
        @(negedge clk);
        cfg_bursts = 8'd3; cfg_period = 16'd8; cfg_off = 16'd4;
        pwr_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R8 pre-abort", int'(sw_on), exp_on(i, 3, 8, 4));
        end
        pwr_en = 1'b0;
        #1 chk("R8 abort sw", int'(sw_on), 0);
        @(negedge clk);
        chk("R8 abort busy", int'(busy), 0);
        run_check(3, 8, 4, 3, 1'b0);

        // R10 bypass from idle
        @(negedge clk);
        bypass = 1'b1;
        pwr_en = 1'b1;
        #1 chk("R10 bypass follow", int'(sw_on), 1);
        @(negedge clk);
        chk("R10 bypass busy", int'(busy), 0);
        chk("R10 bypass on", int'(sw_on), 1);
        pwr_en = 1'b0;
        #1 chk("R10 bypass off", int'(sw_on), 0);
        @(negedge clk);
        bypass = 1'b0;

        // R10 bypass raised mid-run leaves power held on
        @(negedge clk);
        cfg_bursts = 8'd4; cfg_period = 16'd10; cfg_off = 16'd5;
        pwr_en = 1'b1;
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk("R10 mid-run busy", int'(busy), 1);
        bypass = 1'b1;
        #1 chk("R10 mid-run on", int'(sw_on), 1);
        @(negedge clk);
        chk("R10 mid-run ended", int'(busy), 0);
        bypass = 1'b0;
        @(negedge clk);
        chk("R10 held after bypass", int'(sw_on), 1);
        chk("R10 held busy", int'(busy), 0);
        pwr_en = 1'b0;
        @(negedge clk);

        // random patterns from a fixed seed
        void'($urandom(32'h5eed));
        for (int k = 0; k < 12; k++) begin
            run_check(int'($urandom_range(0, 6)), int'($urandom_range(0, 30)),
                      int'($urandom_range(0, 35)), 4, 1'(k % 3 == 0));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule